// File: doc/BRIEF.md
# Event Log Ring Writer with Sticky Overflow

This block takes fixed-width event records from internal producers and stores them in a circular log held in a small internal memory. It keeps a tail pointer, which the block advances as it stores records, and a head pointer, which software writes to release records it has consumed. A small register interface gives software a control register, a status register with write-one-to-clear flags, and the two pointers. A separate read port lets the consumer fetch any stored record by index.

When a record arrives and the ring has no free slot, the record is dropped and a sticky overflow flag is latched. From then on, nothing more is logged, even after space frees up. Logging only restarts once software clears the flag and then drives the log-enable bit from 0 back to 1. A level interrupt reports the overflow when interrupts are enabled. The event input never stalls: records that cannot be logged are accepted and thrown away.

Top module: `evlog_writer`

## Requirements
- R1: After reset the control register, status register, head and tail all read 0, `irq` is 0 and no record is logged.
- R2: Logging becomes active on a 0-to-1 write of the log-enable bit (CTRL, address 0, bit 0). While logging is active, a record presented with `evt_valid` is stored at index tail, and tail advances by one modulo DEPTH.
- R3: The ring is full when tail+1 equals head modulo DEPTH, so it holds at most DEPTH-1 records. A record that arrives while the ring is full is discarded, tail does not move, and the overflow flag (STATUS, address 1, bit 0) is set.
- R4: While the overflow flag is 1, no record is stored and tail does not move.
- R5: STATUS bit 1 (record-logged flag) is set in the cycle after a record is stored.
- R6: STATUS bits are write-one-to-clear. Writing a mask clears every named bit in the same write. Writing 0 changes nothing. Bits 2 and 6 are reserved flag positions and read 0 in this block.
- R7: `irq` is 1 exactly when the overflow flag is 1 and the interrupt-enable bit (CTRL bit 1) is 1.
- R8: After an overflow, logging resumes only when the overflow flag has been cleared and log-enable has then gone from 0 to 1. Clearing the flag alone does not resume logging. Writing 1 to log-enable while it is already 1 does not resume logging either.
- R9: `evt_ready` is always 1. Records presented while logging is disabled, or while the overflow flag is set, are accepted and dropped, and tail is unchanged.
- R10: Writing address 2 sets head to the written value modulo DEPTH, which frees slots for new records. Address 2 reads back head and address 3 reads back tail.
- R11: Clearing the overflow flag and toggling log-enable leave head, tail and every stored record unchanged.
- R12: If an overflow is detected in the same cycle that software writes 1 to clear STATUS bit 0, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event record present |
| evt_ready | output | 1 | Record accepted (always 1) |
| evt_data | input | DATA_W | Event record |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 CTRL, 1 STATUS, 2 HEAD, 3 TAIL |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr (combinational) |
| ent_idx | input | PTR_W | Log slot to read |
| ent_data | output | DATA_W | Record stored at ent_idx |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=16. With that depth, seven records fill the ring, so the full boundary, pointer wraparound and repeated overflows are all reached within a few dozen cycles. The scoreboard compares every record read back through the slot port against the order in which records were accepted. This shows that a recovery sequence leaves older records intact. The run also places an overflow and a clear of the same flag in one cycle, and checks both a reset-time write of 1 to log-enable and a second write of 1 while log-enable is already 1.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    // Status register layout (bit positions are decoded by software)
    localparam int STAT_W     = 8;
    localparam int ST_OVF     = 0;
    localparam int ST_LOGGED  = 1;
    localparam int ST_CMDWAIT = 2;
    localparam int ST_PPR     = 6;

    // Flags this block can raise; others stay 0
    localparam logic [STAT_W-1:0] STAT_LIVE =
        STAT_W'((1 << ST_OVF) | (1 << ST_LOGGED));

    // Control register layout
    localparam int CT_LOG_EN = 0;
    localparam int CT_INT_EN = 1;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_HEAD = 2'd2,
        SEL_TAIL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic int_en;   // bit 1
        logic log_en;   // bit 0
    } ctrl_t;

    // Outcome of one presented event
    typedef struct packed {
        logic store;
        logic overflow;
    } evt_act_t;

    // Sticky flag update: a new set wins over a same-cycle clear
    function automatic logic [STAT_W-1:0] w1c_next(
        input logic [STAT_W-1:0] cur,
        input logic [STAT_W-1:0] setv,
        input logic [STAT_W-1:0] clrv
    );
        return (cur & ~clrv) | setv;
    endfunction

endpackage

// File: rtl/evlog_ptrs.sv
module evlog_ptrs
    import evlog_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int REG_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic             active,
    input  logic             wr_head,
    input  logic [REG_W-1:0] wdata,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             full,
    output evt_act_t         act
);
    logic [PTR_W-1:0] tail_nx;

    always_comb begin
        tail_nx      = tail + 1'b1;
        full         = (tail_nx == head);
        act.store    = evt_valid & active & ~full;
        act.overflow = evt_valid & active & full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else begin
            if (wr_head)   head <= wdata[PTR_W-1:0];
            if (act.store) tail <= tail_nx;
        end
    end
endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
    import evlog_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [REG_W-1:0]  wdata,
    input  evt_act_t          act,
    output ctrl_t             ctrl_q,
    output logic [STAT_W-1:0] stat_q,
    output logic              active,
    output logic              irq
);
    logic              armed_q;
    logic              en_rise;
    logic [STAT_W-1:0] setv;
    logic [STAT_W-1:0] clrv;
    ctrl_t             ctrl_d;

    always_comb begin
        ctrl_d.log_en    = wdata[CT_LOG_EN];
        ctrl_d.int_en    = wdata[CT_INT_EN];
        en_rise          = wr_ctrl & wdata[CT_LOG_EN] & ~ctrl_q.log_en;
        setv             = '0;
        setv[ST_OVF]     = act.overflow;
        setv[ST_LOGGED]  = act.store;
        clrv             = wr_stat ? (wdata[STAT_W-1:0] & STAT_LIVE) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_d;
            if (act.overflow)  armed_q <= 1'b0;
            else if (en_rise)  armed_q <= 1'b1;
            stat_q <= w1c_next(stat_q, setv, clrv);
        end
    end

    assign active = ctrl_q.log_en & armed_q & ~stat_q[ST_OVF];
    assign irq    = stat_q[ST_OVF] & ctrl_q.int_en;
endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
    import evlog_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [PTR_W-1:0]  ent_idx,
    output logic [DATA_W-1:0] ent_data,
    output logic              irq
);
    reg_sel_e          sel;
    logic              wr_ctrl, wr_stat, wr_head;
    logic              log_active, ring_full;
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [STAT_W-1:0] stat_q;
    ctrl_t             ctrl_q;
    evt_act_t          act;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
    assign wr_stat   = reg_wr && (sel == SEL_STAT);
    assign wr_head   = reg_wr && (sel == SEL_HEAD);
    assign evt_ready = 1'b1;

    evlog_ptrs #(.DEPTH(DEPTH), .REG_W(REG_W)) u_ptrs (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .active(log_active),
        .wr_head(wr_head), .wdata(reg_wdata), .head(head_q), .tail(tail_q),
        .full(ring_full), .act(act)
    );

    evlog_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
        .wdata(reg_wdata), .act(act), .ctrl_q(ctrl_q), .stat_q(stat_q),
        .active(log_active), .irq(irq)
    );

    evlog_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(act.store), .waddr(tail_q), .wdata(evt_data),
        .raddr(ent_idx), .rdata(ent_data)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: reg_rdata = REG_W'(ctrl_q);
            SEL_STAT: reg_rdata = REG_W'(stat_q);
            SEL_HEAD: reg_rdata = REG_W'(head_q);
            SEL_TAIL: reg_rdata = REG_W'(tail_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evlog_writer_chk.sv
module evlog_writer_chk #(
    parameter int PTR_W  = 4,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_valid,
    input logic              active,
    input logic              full,
    input logic              wr_ctrl,
    input logic              wr_stat,
    input logic              clr0,
    input logic              int_en,
    input logic              log_en,
    input logic              irq,
    input logic [PTR_W-1:0]  tail,
    input logic [STAT_W-1:0] stat
);
    a_r3_full_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && active && full) |=> stat[0]);

    a_r3_full_holds_tail: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && active && full) |=> $stable(tail));

    a_r4_ovf_freezes_tail: assert property (@(posedge clk) disable iff (rst)
        stat[0] |=> $stable(tail));

    a_r5_store_flags: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && active && !full) |=>
            (stat[1] && tail == PTR_W'($past(tail) + 1'b1)));

    a_r7_ovf_irq: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && active && full && int_en && !wr_ctrl) |=> irq);

    a_r8_no_rearm_without_edge: assert property (@(posedge clk) disable iff (rst)
        (!active && log_en && !wr_ctrl && !stat[0]) |=> !active);

    a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && active && full && wr_stat && clr0) |=> stat[0]);
endmodule

bind evlog_writer evlog_writer_chk #(.PTR_W(PTR_W), .STAT_W(evlog_pkg::STAT_W)) u_chk (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .active(log_active),
    .full(ring_full), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .clr0(reg_wdata[0]), .int_en(ctrl_q.int_en), .log_en(ctrl_q.log_en),
    .irq(irq), .tail(tail_q), .stat(stat_q)
);

// File: tb/evlog_writer_test.sv
module evlog_writer_test;
    localparam int D  = 8;
    localparam int DW = 16;
    localparam int RW = 32;
    localparam int PW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evt_valid = 1'b0;
    logic          evt_ready;
    logic [DW-1:0] evt_data = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [PW-1:0] ent_idx = '0;
    logic [DW-1:0] ent_data;
    logic          irq;

    always #5 clk = ~clk;

    evlog_writer #(.DEPTH(D), .DATA_W(DW), .REG_W(RW)) uut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_data(evt_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ent_idx(ent_idx),
        .ent_data(ent_data), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q[$];

    // Reference model of the requirements
    int m_head = 0, m_tail = 0;
    bit m_ovf = 0, m_log = 0, m_en = 0, m_ie = 0, m_arm = 0;

    function automatic bit m_active();
        return m_en && m_arm && !m_ovf;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int a, output int v);
        reg_addr = 2'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic check_state(input string req);
        int v;
        rd_reg(0, v); chk(req, "ctrl", v, {30'd0, m_ie, m_en});
        rd_reg(1, v); chk(req, "status", v, {30'd0, m_log, m_ovf});
        rd_reg(2, v); chk(req, "head", v, m_head);
        rd_reg(3, v); chk(req, "tail", v, m_tail);
        chk(req, "irq", int'(irq), int'(m_ovf && m_ie));
    endtask

    // Driver: presents a record and pushes the expected entry
    task automatic send(input logic [DW-1:0] d, input bit clr, input int mask);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_data  = d;
        if (clr) begin
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = RW'(mask);
            m_ovf = m_ovf && !mask[0];
            m_log = m_log && !mask[1];
        end
        #1;
        chk("R9", "evt_ready", int'(evt_ready), 1);
        if (m_active()) begin
            if (((m_tail + 1) % D) == m_head) begin
                m_ovf = 1; m_arm = 0;
            end else begin
                exp_q.push_back(d);
                m_tail = (m_tail + 1) % D;
                m_log  = 1;
            end
        end
        @(negedge clk);
        evt_valid = 1'b0;
        reg_wr    = 1'b0;
    endtask

    task automatic wreg(input int a, input int v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = RW'(v);
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            0: begin
                if (v[0] && !m_en) m_arm = 1;
                m_en = v[0]; m_ie = v[1];
            end
            1: begin
                m_ovf = m_ovf && !v[0];
                m_log = m_log && !v[1];
            end
            2: m_head = v % D;
            default: ;
        endcase
    endtask

    // Monitor: pops the oldest expected record and compares the stored one
    task automatic consume(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] e;
            ent_idx = PW'(m_head);
            #1;
            if (exp_q.size() == 0) begin
                chk(req, "queue empty", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(req, "entry", int'(ent_data), int'(e));
            end
            wreg(2, (m_head + 1) % D);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");

        // R9: disabled logging drops records
        send(16'hD001, 0, 0);
        check_state("R9");

        // R2/R5: enable with interrupts, store three
        wreg(0, 3);
        for (int i = 0; i < 3; i++) send(DW'(16'hA000 + i), 0, 0);
        check_state("R2");
        consume(2, "R2");
        check_state("R10");

        // R6: clear logged flag, zero write has no effect
        wreg(1, 0);
        check_state("R6");
        wreg(1, 2);
        check_state("R6");

        // R3: fill to capacity (D-1), then overflow
        for (int i = 0; i < 6; i++) send(DW'(16'hB000 + i), 0, 0);
        check_state("R3");
        send(16'hBEEF, 0, 0);
        check_state("R3");
        chk("R7", "irq at overflow", int'(irq), 1);
        send(16'hBEE0, 0, 0);
        check_state("R4");

        // R7: interrupt follows enable bit
        wreg(0, 1);
        check_state("R7");
        wreg(0, 3);
        check_state("R7");

        // R6/R8: clear both flags in one write, logging stays off
        wreg(1, 32'h43);
        check_state("R6");
        consume(3, "R11");
        send(16'hC001, 0, 0);
        check_state("R8");
        wreg(0, 3);
        send(16'hC002, 0, 0);
        check_state("R8");

        // R11/R8: toggle through 0 then back to 1
        wreg(0, 2);
        wreg(0, 3);
        check_state("R11");
        send(16'hC003, 0, 0);
        check_state("R8");
        consume(exp_q.size(), "R11");
        check_state("R11");

        // R12: overflow and clear of bit 0 in one cycle, plus bit 1 clear
        for (int i = 0; i < D - 1; i++) send(DW'(16'hE000 + i), 0, 0);
        check_state("R3");
        send(16'hEEEE, 1, 3);
        check_state("R12");
        chk("R12", "overflow bit", int'(m_ovf), 1);

        // R10: head write taken modulo depth
        consume(exp_q.size(), "R10");
        wreg(2, D + 5);
        rd_reg(2, v);
        chk("R10", "head modulo", v, 5);
        check_state("R10");

        summary();
        $finish;
    end
endmodule